// File: doc/BRIEF.md
# Masked Global Interrupt Aggregator

This block collects interrupt requests from four serial channels, twelve multi-purpose pins, an optional parallel-port source and a power-down request, and folds them into one active-high host interrupt. Software sees one 32-bit word. The lower half shows the live source states. The upper half holds one enable bit per source. Each pin level can be inverted by its own control input, so any pin can act as an active-high or an active-low interrupt.

Two status positions depend on configuration. Bit 4 shows pin 0, or the parallel-port line when the operating mode is 01. Bit 5 shows pin 1 when the configuration selector is 00. For any other selector value, bit 5 is a sticky power-down flag that a register read clears. In operating mode 10 the pins act as an identifier input, and none of them can raise the host interrupt, whatever the enable bits hold.

A read request is answered with registered read data on the next clock. A write loads only the enable half of the word. The host interrupt is the registered OR of every source that is both active and enabled.

Top module: `irqagg_top`

## Requirements
- R1: After a read request, reg_rdata bits 3:0 show ch_irq[3:0] (bit n is channel n) from the clock edge where reg_rd was high. reg_rdata changes only on such an edge.
- R2: Status bits 15:6 show the internal state of pins 2 to 11 (bit 6 is pin 2). The internal state of pin k is pin_raw[k] XOR pin_inv[k].
- R3: Status bit 4 shows the internal state of pin 0 when op_mode is not 01, and par_irq when op_mode is 01. Enable bit 20 gates whichever of these two sources bit 4 is showing.
- R4: Status bit 5 shows the internal state of pin 1 when cfg_sel is 00, and the power-down flag otherwise. Enable bit 21 gates whichever of these two sources bit 5 is showing. When cfg_sel is not 00, pin 1 is not an interrupt source.
- R5: While cfg_sel is not 00, a pd_req pulse sets the flag on the next clock. A read returns the flag as set and clears it. If pd_req is high in the same cycle as the read, the flag stays set.
- R6: After reset, enable bits 31:16 all read as 1.
- R7: A write loads reg_wdata[31:16] into the enable bits. Bits 15:0 of a write have no effect.
- R8: host_irq is the OR of all sources that are active and enabled, registered, so it changes one clock after a source or an enable changes. Channel n is enabled by bit 16+n. Pin k, for k from 2 to 11, is enabled by bit 20+k.
- R9: When op_mode is 10, no pin can assert host_irq, but channel and power-down sources still can. The status bits still show the pin states.
- R10: host_irq is held low during reset and on the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_irq | input | 4 | Serial channel interrupt lines |
| pin_raw | input | 12 | Raw multi-purpose pin levels |
| pin_inv | input | 12 | Per-pin invert control |
| par_irq | input | 1 | Parallel-port interrupt line |
| pd_req | input | 1 | Power-down request pulse |
| op_mode | input | 2 | Operating mode |
| cfg_sel | input | 2 | Local configuration selector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Combined host interrupt, active high |

## Verification
Channel patterns 1010 and 0101 are used against a single enabled channel. They show that each channel is gated by its own enable bit and that the bit order is not swapped. Pins are driven first through the raw level and then with every invert control set and the raw levels low. This separates the inversion from the raw path, and the same pins are then run in identifier mode to tell status reporting apart from interrupt suppression. Bits 4 and 5 are exercised on both sides of their mode and selector switch. The power-down flag is read alone and with a request in the same cycle, which tells a lost request apart from a kept one.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned HALF_W   = REG_W / 2;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned NUM_PIN  = 12;
  // Bit positions that software decodes
  localparam int unsigned ALT0_BIT = NUM_CH;       // pin0 or parallel port
  localparam int unsigned ALT1_BIT = NUM_CH + 1;   // pin1 or power-down flag
  localparam int unsigned PIN_LO   = NUM_CH + 2;   // first plain pin bit

  typedef enum logic [1:0] {
    MODE_PLAIN0 = 2'b00,
    MODE_PARPORT = 2'b01,
    MODE_IDENT  = 2'b10,
    MODE_PLAIN3 = 2'b11
  } op_mode_e;
endpackage

// File: rtl/irqagg_pin_cond.sv
module irqagg_pin_cond #(
  parameter int unsigned NUM_PIN = 12
) (
  input  logic [NUM_PIN-1:0] pin_raw,
  input  logic [NUM_PIN-1:0] pin_inv,
  output logic [NUM_PIN-1:0] pin_int
);
  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    assign pin_int[k] = pin_raw[k] ^ pin_inv[k];
  end
endmodule

// File: rtl/irqagg_pd_flag.sv
module irqagg_pd_flag (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req,
  input  logic rd,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) flag_q <= 1'b0;
    else if (req)       flag_q <= 1'b1;
    else if (rd)        flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R5
  pd_set_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && req) |=> flag_q);

  // R5
  pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rd && !req) |=> !flag_q);
endmodule

// File: rtl/irqagg_mask_regs.sv
module irqagg_mask_regs #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [MASK_W-1:0] wdata,
  output logic [MASK_W-1:0] mask
);
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '1;
    else if (wr) mask_q <= wdata;
  end

  assign mask = mask_q;

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mask_q));

  // R6
  mask_reset_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '1));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned CH_N  = NUM_CH,
  parameter int unsigned PIN_N = NUM_PIN,
  parameter int unsigned DW    = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_N-1:0]  ch_irq,
  input  logic [PIN_N-1:0] pin_raw,
  input  logic [PIN_N-1:0] pin_inv,
  input  logic             par_irq,
  input  logic             pd_req,
  input  logic [1:0]       op_mode,
  input  logic [1:0]       cfg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             host_irq
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned A0 = CH_N;
  localparam int unsigned A1 = CH_N + 1;
  localparam int unsigned PL = CH_N + 2;

  logic [PIN_N-1:0] pin_int;
  logic [HW-1:0]    mask;
  logic [HW-1:0]    status;
  logic [HW-1:0]    active_src;
  logic             pd_flag;
  logic             pd_enable;
  logic             par_mode;
  logic             id_mode;
  logic             ch_hit;
  logic             pd_hit;
  logic [DW-1:0]    rdata_q;
  logic             host_q;

  assign par_mode  = (op_mode == MODE_PARPORT);
  assign id_mode   = (op_mode == MODE_IDENT);
  assign pd_enable = (cfg_sel != 2'b00);

  irqagg_pin_cond #(.NUM_PIN(PIN_N)) u_pin_cond (
    .pin_raw (pin_raw),
    .pin_inv (pin_inv),
    .pin_int (pin_int)
  );

  irqagg_pd_flag u_pd_flag (
    .clk    (clk),
    .rst    (rst),
    .enable (pd_enable),
    .req    (pd_req),
    .rd     (reg_rd),
    .flag   (pd_flag)
  );

  irqagg_mask_regs #(.MASK_W(HW)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata[DW-1:HW]),
    .mask  (mask)
  );

  // Status view, lower half of the register word
  always_comb begin
    status          = '0;
    status[CH_N-1:0] = ch_irq;
    status[A0]      = par_mode ? par_irq : pin_int[0];
    status[A1]      = pd_enable ? pd_flag : pin_int[1];
    status[HW-1:PL] = pin_int[PIN_N-1:2];
  end

  // Sources that may raise the host line
  always_comb begin
    active_src           = '0;
    active_src[CH_N-1:0] = ch_irq & mask[CH_N-1:0];
    if (par_mode) active_src[A0] = par_irq & mask[A0];
    else          active_src[A0] = pin_int[0] & mask[A0] & ~id_mode;
    if (pd_enable) active_src[A1] = pd_flag & mask[A1];
    else           active_src[A1] = pin_int[1] & mask[A1] & ~id_mode;
    active_src[HW-1:PL]  = pin_int[PIN_N-1:2] & mask[HW-1:PL] & {(PIN_N-2){~id_mode}};
  end

  assign ch_hit = |(ch_irq & mask[CH_N-1:0]);
  assign pd_hit = pd_enable & pd_flag & mask[A1];

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= {mask, status};
  end

  always_ff @(posedge clk) begin
    if (rst) host_q <= 1'b0;
    else     host_q <= |active_src;
  end

  assign reg_rdata = rdata_q;
  assign host_irq  = host_q;

  // R10
  host_reset_low_chk: assert property (@(posedge clk)
    rst |=> !host_q);

  // R9
  ident_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (id_mode && !ch_hit && !pd_hit) |=> !host_q);

  // R8
  host_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!ch_hit && !(|(status & mask))) |=> !host_q);

  // R7
  wr_upper_only_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_wdata[HW-1:0] != '0)) |=> (mask == $past(reg_wdata[DW-1:HW])));

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(rdata_q));
endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ch_irq = '0;
  logic [11:0] pin_raw = '0;
  logic [11:0] pin_inv = '0;
  logic        par_irq = 1'b0;
  logic        pd_req = 1'b0;
  logic [1:0]  op_mode = 2'b00;
  logic [1:0]  cfg_sel = 2'b00;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irqagg_top u_irqagg_top (
    .clk(clk), .rst(rst), .ch_irq(ch_irq), .pin_raw(pin_raw), .pin_inv(pin_inv),
    .par_irq(par_irq), .pd_req(pd_req), .op_mode(op_mode), .cfg_sel(cfg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // Monitor: compare read data one clock after the request
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read data with no expected item, actual %h", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_read_pd(input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1;
    pd_req = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    pd_req = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic pulse_pd();
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (host_irq !== e) begin
      fails++;
      $display("FAIL %s: host_irq actual %b expected %b", t, host_irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R10: held low in reset
    check_irq(1'b0, "R10 in reset");
    @(negedge clk);
    rst = 1'b0;
    check_irq(1'b0, "R10 after reset");
    do_read(32'hFFFF_0000, "R6 reset masks");

    // R1 / R8 channels
    ch_irq = 4'b1010;
    check_irq(1'b1, "R8 channels enabled");
    do_read(32'hFFFF_000A, "R1 channel status");
    do_write(32'h0000_FFFF);
    check_irq(1'b0, "R8 channels masked");
    do_read(32'h0000_000A, "R7 low half ignored");
    do_write(32'h0002_0000);
    check_irq(1'b1, "R8 channel1 enabled");
    ch_irq = 4'b0101;
    check_irq(1'b0, "R8 channel1 only gate");
    ch_irq = 4'b0000;
    do_write(32'hFFFF_0000);

    // R2 pins and inversion
    pin_raw = 12'h004;
    check_irq(1'b1, "R2 pin2 raw");
    do_read(32'hFFFF_0040, "R2 pin2 status");
    pin_raw = 12'h000;
    pin_inv = 12'hFFF;
    check_irq(1'b1, "R2 inverted pins");
    do_read(32'hFFFF_FFF0, "R2 inverted status");
    // R9 identifier mode
    op_mode = 2'b10;
    check_irq(1'b0, "R9 pins suppressed");
    do_read(32'hFFFF_FFF0, "R9 status still shown");
    ch_irq = 4'b0001;
    check_irq(1'b1, "R9 channel still asserts");
    ch_irq = 4'b0000;
    pin_inv = 12'h000;

    // R3 bit 4 alternates
    op_mode = 2'b01;
    par_irq = 1'b1;
    check_irq(1'b1, "R3 parallel port");
    do_read(32'hFFFF_0010, "R3 parallel status");
    par_irq = 1'b0;
    pin_raw = 12'h001;
    check_irq(1'b0, "R3 pin0 not source in mode 01");
    do_read(32'hFFFF_0000, "R3 pin0 hidden");
    op_mode = 2'b00;
    check_irq(1'b1, "R3 pin0 source");
    do_read(32'hFFFF_0010, "R3 pin0 status");
    do_write(32'hFFEF_0000);
    check_irq(1'b0, "R3 bit20 masks");
    do_write(32'hFFFF_0000);
    pin_raw = 12'h000;

    // R4 / R5 power-down flag
    cfg_sel = 2'b01;
    pin_raw = 12'h002;
    check_irq(1'b0, "R4 pin1 not source");
    do_read(32'hFFFF_0000, "R4 flag clear");
    pulse_pd();
    check_irq(1'b1, "R5 flag asserts host");
    do_read(32'hFFFF_0020, "R5 flag set");
    do_read(32'hFFFF_0000, "R5 flag cleared");
    check_irq(1'b0, "R5 host drops");
    pulse_pd();
    do_read_pd(32'hFFFF_0020, "R5 read with request");
    do_read(32'hFFFF_0020, "R5 request kept");
    do_read(32'hFFFF_0000, "R5 cleared afterwards");
    cfg_sel = 2'b00;
    check_irq(1'b1, "R4 pin1 source");
    do_read(32'hFFFF_0020, "R4 pin1 status");
    do_write(32'hFFDF_0000);
    check_irq(1'b0, "R4 bit21 masks");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule